// File: doc/BRIEF.md
# March-algorithm memory self-test sequencer

This block runs a march test on a single-port RAM that it drives directly. A march test is an ordered list of elements. Each element sweeps the whole address space, either upward or in the exact reverse order. At every address it applies a short list of operations before it moves to the next address. Each operation is either a write of an all-zeros or all-ones word, or a read that must return such a word. Four algorithms are built in. Two options can be added to any of them: a programmable idle gap between elements, for retention testing, and an extra read at the end of certain elements so that every cell is read as both 0 and 1, for stuck-open cells.

A pulse on `start` loads the algorithm and option pins and begins the run. `busy` stays high until the final read has been compared. `done` then stays high until the next start. The first mismatching read sets `fail` and captures the address and element index. The run always finishes the whole algorithm. All pins are plain control and status levels, and no data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. The RAM is assumed to accept one access per cycle and to return read data one cycle after the read.

Top module: `march_bist`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `ram_en` are all 0.
- R2: `alg_sel` chooses the algorithm. Elements are listed as direction(operations), where rX reads and expects X and wX writes X. Code 0 is {up(w0); up(r0,w1); down(r1,w0)}, 5 accesses per address. Code 1 is {up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0)}, 10 per address. Code 2 is {up(w0); up(r0,w1,w0,w1); up(r1,w0,w1,w0); down(r0,w1,w0); down(r0,w1,w0)}, 15 per address. Code 3 is {up(w0); up(r0,w1,r1,w0,r0,w1); up(r1,w0,w1,w0); down(r0,w1,w0); down(r0,w1,w0)}, 17 per address. Elements are numbered from 0.
- R3: An up element visits addresses 0 to 2^AW-1 in order. A down element visits the exact reverse order. Every operation of an element is applied to one address before the next address.
- R4: Every write drives all data bits to the operation's value. Every read is compared, one cycle later, with the operation's value replicated across all bits. Any differing bit is a mismatch.
- R5: The first mismatch sets `fail` and captures `fail_addr` and `fail_elem`. Later mismatches leave all three unchanged. The run still performs every access of the algorithm.
- R6: When `ret_en` is 1 and `ret_dly` is nonzero, `ret_dly` idle cycles with `ram_en` at 0 are inserted between each pair of consecutive elements. No gap is inserted before the first element or after the last.
- R7: When `so_en` is 1, every element whose first operation is a read and whose last operation is a write gets one more read that expects the last written value. This adds 2, 4, 4 and 4 accesses per address to codes 0 to 3.
- R8: `busy` is high for exactly (accesses + gap cycles + 1) cycles. `done` then rises and holds until the next start. A mismatch on the very last read shows on `fail` in the same cycle that `done` rises.
- R9: `start` is ignored while `busy` is high. A start from idle or from done clears `done`, `fail`, `fail_addr` and `fail_elem`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (one-cycle pulse) |
| alg_sel | input | 2 | Algorithm code, sampled at start |
| ret_en | input | 1 | Enable idle gaps between elements |
| ret_dly | input | DLYW | Gap length in cycles |
| so_en | input | 1 | Enable the extra closing read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | At least one mismatch seen |
| fail_addr | output | AW | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | Access is a write |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after the read |

## Verification
The final compare and the end of the run land on the same clock edge. The last read is checked during the drain cycle, and that same edge moves the sequencer to done. To provoke this, the bench's RAM model flips one bit of the read data returned on the final access of a run with the extra-read option. The bench then checks that `fail` was low one cycle before `done` rose and is high in the cycle `done` rises, with the last element and address 0 captured. Pairs of stuck bits at two addresses show the direction of each sweep: the upward sweep meets the lower address first, and the downward sweep meets the higher one first.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int MAX_OPS = 7;
  localparam int EW = 3;
  localparam int OW = 3;

  typedef struct packed {
    logic wr;
    logic val;
  } op_t;

  typedef struct packed {
    logic             down;
    logic [OW-1:0]    nops;
    op_t [MAX_OPS-1:0] ops;
  } elem_t;

  // codes: two bits per op, op0 in the low bits; 00 r0, 01 r1, 10 w0, 11 w1
  function automatic elem_t mk_elem(input logic down, input int unsigned n,
                                    input logic [2*MAX_OPS-1:0] codes, input logic so);
    elem_t e;
    e = '0;
    e.down = down;
    e.nops = OW'(n);
    for (int i = 0; i < MAX_OPS; i++) e.ops[i] = codes[2*i +: 2];
    if (so && !e.ops[0].wr && e.ops[n-1].wr) begin
      e.ops[n] = '{wr: 1'b0, val: e.ops[n-1].val};
      e.nops   = OW'(n + 1);
    end
    return e;
  endfunction

  function automatic int unsigned num_elems(input logic [1:0] alg);
    case (alg)
      2'd0:    return 3;
      2'd1:    return 6;
      default: return 5;
    endcase
  endfunction

  function automatic elem_t get_elem(input logic [1:0] alg, input logic [EW-1:0] idx,
                                     input logic so);
    elem_t e;
    e = mk_elem(1'b0, 1, 14'b10, so);
    case (alg)
      2'd0: case (idx)
        3'd1:    e = mk_elem(1'b0, 2, 14'b1100, so);
        3'd2:    e = mk_elem(1'b1, 2, 14'b1001, so);
        default: ;
      endcase
      2'd1: case (idx)
        3'd1:    e = mk_elem(1'b0, 2, 14'b1100, so);
        3'd2:    e = mk_elem(1'b0, 2, 14'b1001, so);
        3'd3:    e = mk_elem(1'b1, 2, 14'b1100, so);
        3'd4:    e = mk_elem(1'b1, 2, 14'b1001, so);
        3'd5:    e = mk_elem(1'b0, 1, 14'b00, so);
        default: ;
      endcase
      default: case (idx)
        3'd1:    e = alg[0] ? mk_elem(1'b0, 6, 14'b110010011100, so)
                            : mk_elem(1'b0, 4, 14'b11101100, so);
        3'd2:    e = mk_elem(1'b0, 4, 14'b10111001, so);
        3'd3,
        3'd4:    e = mk_elem(1'b1, 3, 14'b101100, so);
        default: ;
      endcase
    endcase
    return e;
  endfunction
endpackage

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DLYW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      alg_sel,
  input  logic            ret_en,
  input  logic            so_en,
  input  logic [DLYW-1:0] ret_dly,
  output logic            launch,
  output logic            busy,
  output logic            done,
  output logic            acc_en,
  output logic            acc_wr,
  output logic            acc_val,
  output logic [AW-1:0]   acc_addr,
  output logic [EW-1:0]   acc_elem
);
  typedef enum logic [2:0] {S_IDLE, S_RUN, S_WAIT, S_DRAIN, S_DONE} st_e;

  st_e             st;
  logic [1:0]      alg_q;
  logic            ret_q, so_q;
  logic [DLYW-1:0] dly_q, wcnt;
  logic [EW-1:0]   elem;
  logic [OW-1:0]   opi;
  logic [AW-1:0]   cnt;
  elem_t           cur;
  op_t             op;
  logic            last_op, last_addr, last_elem;

  always_comb begin
    cur       = get_elem(alg_q, elem, so_q);
    op        = cur.ops[opi];
    last_op   = (opi == cur.nops - 1'b1);
    last_addr = &cnt;
    last_elem = (elem == EW'(num_elems(alg_q) - 1));
  end

  assign launch   = start && (st == S_IDLE || st == S_DONE);
  assign busy     = (st == S_RUN) || (st == S_WAIT) || (st == S_DRAIN);
  assign done     = (st == S_DONE);
  assign acc_en   = (st == S_RUN);
  assign acc_wr   = op.wr;
  assign acc_val  = op.val;
  assign acc_addr = cur.down ? ~cnt : cnt;
  assign acc_elem = elem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; alg_q <= '0; ret_q <= 1'b0; so_q <= 1'b0; dly_q <= '0;
      wcnt <= '0; elem <= '0; opi <= '0; cnt <= '0;
    end else if (launch) begin
      alg_q <= alg_sel; ret_q <= ret_en; so_q <= so_en; dly_q <= ret_dly;
      elem <= '0; opi <= '0; cnt <= '0; st <= S_RUN;
    end else begin
      case (st)
        S_RUN: begin
          if (!last_op) opi <= opi + 1'b1;
          else begin
            opi <= '0;
            if (!last_addr) cnt <= cnt + 1'b1;
            else begin
              cnt <= '0;
              if (last_elem) st <= S_DRAIN;
              else begin
                elem <= elem + 1'b1;
                if (ret_q && dly_q != '0) begin
                  wcnt <= dly_q;
                  st   <= S_WAIT;
                end
              end
            end
          end
        end
        S_WAIT: begin
          if (wcnt == 1) st <= S_RUN;
          else wcnt <= wcnt - 1'b1;
        end
        S_DRAIN: st <= S_DONE;
        default: ;
      endcase
    end
  end

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && $past(acc_en) && acc_elem == $past(acc_elem) && !cur.down
    |-> (acc_addr == $past(acc_addr) || acc_addr == $past(acc_addr) + 1'b1));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && $past(acc_en) && acc_elem == $past(acc_elem) && cur.down
    |-> (acc_addr == $past(acc_addr) || acc_addr == $past(acc_addr) - 1'b1));

  assert_done_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st == S_DRAIN));

  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == S_WAIT) && st == S_WAIT |-> !acc_en && $stable(elem));
endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import march_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rd_en,
  input  logic          exp_val,
  input  logic [AW-1:0] rd_addr,
  input  logic [EW-1:0] rd_elem,
  input  logic [DW-1:0] rdata,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [EW-1:0] fail_elem
);
  logic          v_q, x_q;
  logic [AW-1:0] a_q;
  logic [EW-1:0] e_q;
  logic          mism;

  assign mism = v_q && (rdata != {DW{x_q}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0; x_q <= 1'b0; a_q <= '0; e_q <= '0;
      fail <= 1'b0; fail_addr <= '0; fail_elem <= '0;
    end else begin
      v_q <= rd_en;
      x_q <= exp_val;
      a_q <= rd_addr;
      e_q <= rd_elem;
      if (clear) begin
        fail <= 1'b0; fail_addr <= '0; fail_elem <= '0;
      end else if (mism && !fail) begin
        fail      <= 1'b1;
        fail_addr <= a_q;
        fail_elem <= e_q;
      end
    end
  end

  assert_first_fail_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fail) && fail |-> $stable(fail_addr) && $stable(fail_elem));

  assert_fail_from_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(v_q));
endmodule

// File: rtl/march_bist.sv
module march_bist #(
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int DLYW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      alg_sel,
  input  logic            ret_en,
  input  logic [DLYW-1:0] ret_dly,
  input  logic            so_en,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [AW-1:0]   fail_addr,
  output logic [2:0]      fail_elem,
  output logic            ram_en,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  input  logic [DW-1:0]   ram_rdata
);
  logic       launch, acc_wr, acc_val;
  logic [2:0] acc_elem;

  march_seq #(.AW(AW), .DLYW(DLYW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel), .ret_en(ret_en),
    .so_en(so_en), .ret_dly(ret_dly), .launch(launch), .busy(busy), .done(done),
    .acc_en(ram_en), .acc_wr(acc_wr), .acc_val(acc_val), .acc_addr(ram_addr),
    .acc_elem(acc_elem)
  );

  assign ram_we    = acc_wr;
  assign ram_wdata = {DW{acc_val}};

  march_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(launch), .rd_en(ram_en && !acc_wr),
    .exp_val(acc_val), .rd_addr(ram_addr), .rd_elem(acc_elem), .rdata(ram_rdata),
    .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem)
  );

  assert_done_holds_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> $stable(fail) && $stable(fail_addr));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && $past(start) && busy |-> !$fell(fail));
endmodule

// File: tb/test_march_bist.sv
module test_march_bist;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] alg_sel = '0;
  logic       ret_en = 1'b0, so_en = 1'b0;
  logic [7:0] ret_dly = '0;
  logic       busy, done, fail, ram_en, ram_we;
  logic [3:0] fail_addr, ram_addr;
  logic [2:0] fail_elem;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = '0;

  int nchk = 0, nfail = 0;
  int acc_cnt = 0;
  int glitch_at = -1;
  logic [7:0] mem [16];
  logic [7:0] fmask [16];
  logic [7:0] fval [16];

  always #2.5 clk = ~clk;

  march_bist i_march_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel), .ret_en(ret_en),
    .ret_dly(ret_dly), .so_en(so_en), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_elem(fail_elem), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // RAM model with stuck bits and a one-shot read corruption
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we)
        mem[ram_addr] <= (ram_wdata & ~fmask[ram_addr]) | (fval[ram_addr] & fmask[ram_addr]);
      else
        ram_rdata <= ((mem[ram_addr] & ~fmask[ram_addr]) | (fval[ram_addr] & fmask[ram_addr]))
                     ^ ((acc_cnt == glitch_at) ? 8'h01 : 8'h00);
      acc_cnt <= acc_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per_addr(input int a, input bit so);
    int base [4] = '{5, 10, 15, 17};
    int ext  [4] = '{2, 4, 4, 4};
    return base[a] + (so ? ext[a] : 0);
  endfunction

  function automatic int nelem(input int a);
    int ne [4] = '{3, 6, 5, 5};
    return ne[a];
  endfunction

  function automatic int gaps(input int a, input bit ret, input int dl);
    return ret ? (nelem(a) - 1) * dl : 0;
  endfunction

  // first element whose read expects 1 (stuck-at-0 detection)
  function automatic int sa0_elem(input int a, input bit so);
    return (so || a == 3) ? 1 : 2;
  endfunction

  task automatic clear_faults();
    for (int i = 0; i < 16; i++) begin fmask[i] = '0; fval[i] = '0; end
    glitch_at = -1;
  endtask

  int r_ops, r_busy, r_fa, r_fe;
  bit r_fail, r_same;

  task automatic run(input int a, input bit so, input bit ret, input int dl, input bit poke);
    int cyc;
    bit prevf;
    @(negedge clk);
    alg_sel = 2'(a); so_en = so; ret_en = ret; ret_dly = 8'(dl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_ops = 0; r_busy = 0; prevf = 1'b0; cyc = 0;
    while (!done && cyc < 4000) begin
      if (ram_en) r_ops++;
      if (busy) r_busy++;
      if (poke && r_busy == 20) begin start = 1'b1; alg_sel = 2'((a + 1) % 4); so_en = ~so; end
      else start = 1'b0;
      prevf = fail;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    if (!done) chk("R8 run ended (watchdog)", 0, 1);
    r_fail = fail; r_fa = int'(fail_addr); r_fe = int'(fail_elem);
    r_same = fail && !prevf;
  endtask

  initial begin
    #1000000;
    nfail++; nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int a, dl, fa, kind, bitn;
    bit so, ret;
    void'($urandom(32'd4242));
    clear_faults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 ram_en", ram_en, 0);

    // R2 clean runs of each algorithm
    for (int k = 0; k < 4; k++) begin
      run(k, 0, 0, 0, 0);
      chk("R2 access count", r_ops, 16 * per_addr(k, 0));
      chk("R8 busy length", r_busy, 16 * per_addr(k, 0) + 1);
      chk("R4 clean memory passes", r_fail, 0);
    end
    // R7 extra reads
    for (int k = 0; k < 4; k++) begin
      run(k, 1, 0, 0, 0);
      chk("R7 access count", r_ops, 16 * per_addr(k, 1));
      chk("R7 clean pass", r_fail, 0);
    end
    // R6 gaps
    run(0, 0, 1, 5, 0);
    chk("R6 accesses unchanged", r_ops, 80);
    chk("R6 busy with gaps", r_busy, 80 + 10 + 1);
    run(1, 0, 1, 3, 0);
    chk("R6 busy with gaps C", r_busy, 160 + 15 + 1);
    run(2, 0, 0, 9, 0);
    chk("R6 gaps off when disabled", r_busy, 240 + 1);

    // R3 sweep order: two stuck-at-1 bits, the upward read meets address 3 first
    clear_faults();
    fmask[3] = 8'h10; fval[3] = 8'h10; fmask[9] = 8'h02; fval[9] = 8'h02;
    run(0, 0, 0, 0, 0);
    chk("R3 up sweep first address", r_fa, 3);
    chk("R5 element of first fail", r_fe, 1);
    chk("R5 run completes after fail", r_ops, 80);
    // two stuck-at-0 bits, the downward read meets address 9 first
    clear_faults();
    fmask[3] = 8'h80; fmask[9] = 8'h01;
    run(0, 0, 0, 0, 0);
    chk("R3 down sweep first address", r_fa, 9);
    chk("R3 down element index", r_fe, 2);

    // R8 mismatch on the last read lands with done
    clear_faults();
    glitch_at = acc_cnt + 16 * per_addr(0, 1) - 1;
    run(0, 1, 0, 0, 0);
    chk("R8 fail rises with done", r_same, 1);
    chk("R8 last element captured", r_fe, 2);
    chk("R8 last address captured", r_fa, 0);

    // R9 start while busy ignored, then restart clears fail
    clear_faults();
    run(1, 0, 0, 0, 1);
    chk("R9 start ignored while busy", r_ops, 160);
    chk("R9 restart clears fail", r_fail, 0);

    // random mix
    for (int it = 0; it < 14; it++) begin
      clear_faults();
      a = int'($urandom_range(3)); so = 1'($urandom_range(1)); ret = 1'($urandom_range(1));
      dl = int'($urandom_range(6)); fa = int'($urandom_range(15));
      kind = int'($urandom_range(2)); bitn = int'($urandom_range(7));
      if (kind != 0) begin
        fmask[fa] = 8'(1 << bitn);
        fval[fa]  = (kind == 2) ? 8'(1 << bitn) : 8'h00;
      end
      run(a, so, ret, dl, 0);
      chk("R2 random access count", r_ops, 16 * per_addr(a, so));
      chk("R6 random busy length", r_busy, 16 * per_addr(a, so) + gaps(a, ret, dl) + 1);
      chk("R4 random fail flag", r_fail, (kind != 0) ? 1 : 0);
      if (kind != 0) begin
        chk("R5 random fail address", r_fa, fa);
        chk("R5 random fail element", r_fe, (kind == 2) ? 1 : sa0_elem(a, so));
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule